// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache Controller

This block is the coherence controller of one private cache in a small multiprocessor whose caches share an atomic bus. It holds a direct-mapped array of one-word lines, each with a tag, a data word and a single valid bit. The processor sees a valid/ready handshake and has at most one request outstanding. Read hits are served from the array and never touch the bus. Read misses fetch the word over the bus and fill the line.

The cache is write-through and never allocates on a write. Every processor write is broadcast on the bus. A write completes only after the bus has been granted and the transfer acknowledged. A write that hits also refreshes the local copy. A write that misses leaves the line as it was.

A snoop port watches every bus transfer. A write from any other cache to a line held valid here clears that line, so later readers fetch the new value. Several caches may hold the same line at once. The requester identifier on the snoop port lets the cache skip its own broadcasts.

Top module: `snoop_wt_cache`

## Requirements
- R1: Out of reset every line is invalid, `cpuReady` and `busReq` are low, and the first read of any address goes to the bus.
- R2: A read whose address matches a valid line (index = address bits [3:0], tag = the remaining upper bits) completes in the same cycle `cpuValid` is seen. `cpuReady` is high with the stored word on `cpuRdata`, and `busReq` stays low.
- R3: A read miss raises `busReq` in the next cycle with `busWrite`=0 and `busAddr` equal to the request address. It holds the request until a cycle with `busGrant` and `busAck` both high. It completes in that cycle with `cpuRdata` equal to `busRdata`, and it leaves the line valid.
- R4: Every write, hit or miss, raises `busReq` with `busWrite`=1, `busAddr` and `busWdata` from the request, and `busId` equal to the cache identifier. `cpuReady` for a write is never high outside a cycle with `busGrant` and `busAck`.
- R5: A write to an address not held valid does not allocate: the next read of that address goes to the bus.
- R6: A write that hits updates the stored word: the next read of that address completes without the bus and returns the written data.
- R7: A snooped write (`snpWrite`=1) whose `snpId` differs from the cache identifier and whose address matches a valid line invalidates it: the next read of that address goes to the bus.
- R8: A snooped transfer carrying the cache's own identifier, and any snooped read (`snpWrite`=0), leave the array unchanged.
- R9: A snooped write to the same index but a different tag leaves the held line valid.
- R10: A read fill replaces whatever line occupied its index, so the displaced address misses on its next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present, held until completion |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Word address of the request |
| cpuWdata | input | 32 | Write data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | 32 | Read data, valid while `cpuReady` is high on a read |
| busReq | output | 1 | Cache wants the bus |
| busWrite | output | 1 | Transfer kind: 1 = write, 0 = read |
| busAddr | output | 32 | Transfer address |
| busWdata | output | 32 | Transfer write data |
| busId | output | 2 | Identifier of this cache |
| busGrant | input | 1 | Bus granted to this cache |
| busAck | input | 1 | Transfer finished; read data valid |
| busRdata | input | 32 | Read data returned by memory |
| snpValid | input | 1 | A transfer is visible on the shared bus |
| snpWrite | input | 1 | Snooped transfer is a write |
| snpAddr | input | 32 | Snooped address |
| snpId | input | 2 | Identifier of the snooped requester |

## Verification
The assertions assume that the processor holds its request fields steady from `cpuValid` until completion. They also assume that `busAck` comes only while this cache's `busGrant` is high, and, since the bus is atomic, that no other cache's write is snooped during this cache's own transfer. The stimulus keeps to these rules. One task drives each processor access and plays the arbiter and the memory, granting only after it has seen `busReq`. Snoop pulses are issued only between accesses, while the cache is idle.

// File: rtl/snoop_cache_pkg.sv
package snoop_cache_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic fill;   // load tag/data from bus, mark valid
    logic wrUpd;  // overwrite data of a hitting line
  } dpStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/snoop_cache_dp.sv
module snoop_cache_dp
  import snoop_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpId,
  output logic              cpuHit,
  output logic [DATA_W-1:0] hitData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              validBits [LINES];
  logic [TAG_W-1:0]  tagMem    [LINES];
  logic [DATA_W-1:0] dataMem   [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             snpKill;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  assign cpuHit  = validBits[cpuIdx] && (tagMem[cpuIdx] == cpuTag);
  assign hitData = dataMem[cpuIdx];

  // Foreign write to a line held here
  assign snpKill = snpValid && snpWrite && (snpId != ID_W'(MY_ID))
                && validBits[snpIdx] && (tagMem[snpIdx] == snpTag);

  for (genvar i = 0; i < LINES; i++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validBits[i] <= 1'b0;
      end else if (strobe.fill && cpuIdx == IDX_W'(i)) begin
        validBits[i] <= 1'b1;
      end else if (snpKill && snpIdx == IDX_W'(i)) begin
        validBits[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.fill && cpuIdx == IDX_W'(i)) begin
        tagMem[i]  <= cpuTag;
        dataMem[i] <= busRdata;
      end else if (strobe.wrUpd && cpuIdx == IDX_W'(i)) begin
        dataMem[i] <= cpuWdata;
      end
    end
  end

  AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rstN)
    snpKill && !strobe.fill |=> !validBits[$past(snpIdx)]); // R7

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> validBits[$past(cpuIdx)]
                    && tagMem[$past(cpuIdx)] == $past(cpuTag)); // R3

  AST_OWN_SNOOP_INERT: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && snpId == ID_W'(MY_ID) && !strobe.fill
    |=> validBits[$past(snpIdx)] == $past(validBits[snpIdx])); // R8

endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import snoop_cache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuValid,
  input  logic      cpuWrite,
  input  logic      cpuHit,
  input  logic      busGrant,
  input  logic      busAck,
  output logic      busReq,
  output logic      cpuReady,
  output logic      useBusData,
  output dpStrobe_t strobe
);

  ctrlState_t state, stateNext;
  logic       busDone, needBus;

  assign busDone    = (state == ST_BUS) && busGrant && busAck;
  assign needBus    = cpuValid && (cpuWrite || !cpuHit);
  assign busReq     = (state == ST_BUS);
  assign useBusData = (state == ST_BUS);
  assign cpuReady   = ((state == ST_IDLE) && cpuValid && !cpuWrite && cpuHit)
                   || busDone;

  always_comb begin
    strobe       = '0;
    strobe.fill  = busDone && !cpuWrite;
    strobe.wrUpd = busDone && cpuWrite && cpuHit;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (needBus) stateNext = ST_BUS;
      ST_BUS:  if (busDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_WRITE_WAITS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid && cpuWrite && cpuReady |-> busGrant && busAck); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !(busGrant && busAck) |=> busReq); // R3

  AST_READY_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuValid); // R2

endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache
  import snoop_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [ID_W-1:0]   busId,
  input  logic              busGrant,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpId
);

  dpStrobe_t         strobe;
  logic              cpuHit, useBusData;
  logic [DATA_W-1:0] hitData;

  snoop_cache_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuValid   (cpuValid),
    .cpuWrite   (cpuWrite),
    .cpuHit     (cpuHit),
    .busGrant   (busGrant),
    .busAck     (busAck),
    .busReq     (busReq),
    .cpuReady   (cpuReady),
    .useBusData (useBusData),
    .strobe     (strobe)
  );

  snoop_cache_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES),
    .ID_W   (ID_W),
    .MY_ID  (MY_ID)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .busRdata (busRdata),
    .snpValid (snpValid),
    .snpWrite (snpWrite),
    .snpAddr  (snpAddr),
    .snpId    (snpId),
    .cpuHit   (cpuHit),
    .hitData  (hitData)
  );

  // Request is held stable by the processor while the bus is used
  assign busWrite = cpuWrite;
  assign busAddr  = cpuAddr;
  assign busWdata = cpuWdata;
  assign busId    = ID_W'(MY_ID);
  assign cpuRdata = useBusData ? busRdata : hitData;

endmodule

// File: tb/snoop_wt_cache_test.sv
module snoop_wt_cache_test;

  localparam int CLK_PERIOD = 10;
  localparam int MY_ID = 1;
  localparam int NVEC = 9;

  // {write, addr, wdata, expectBus, expectData}
  localparam logic [97:0] VEC [NVEC] = '{
    {1'b0, 32'h10, 32'h0,        1'b1, 32'hC0DE0010}, // R1 R3 cold miss
    {1'b0, 32'h10, 32'h0,        1'b0, 32'hC0DE0010}, // R2 hit
    {1'b1, 32'h10, 32'h11111111, 1'b1, 32'h0},        // R4 write hit
    {1'b0, 32'h10, 32'h0,        1'b0, 32'h11111111}, // R6
    {1'b1, 32'h23, 32'h22222222, 1'b1, 32'h0},        // R4 write miss
    {1'b0, 32'h23, 32'h0,        1'b1, 32'h22222222}, // R5 no allocate
    {1'b0, 32'h23, 32'h0,        1'b0, 32'h22222222}, // R2
    {1'b0, 32'h33, 32'h0,        1'b1, 32'hC0DE0033}, // R10 conflict fill
    {1'b0, 32'h23, 32'h0,        1'b1, 32'h22222222}  // R10 displaced
  };

  logic clk = 0, rstN = 0;
  logic cpuValid = 0, cpuWrite = 0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic cpuReady, busReq, busWrite;
  logic [31:0] cpuRdata, busAddr, busWdata;
  logic [1:0] busId;
  logic busGrant = 0, busAck = 0;
  logic [31:0] busRdata = '0;
  logic snpValid = 0, snpWrite = 0;
  logic [31:0] snpAddr = '0;
  logic [1:0] snpId = '0;

  int nTests = 0, nFail = 0;
  bit finished = 0;
  logic [31:0] memModel [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_wt_cache #(.MY_ID(MY_ID)) uut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuRdata(cpuRdata), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busId(busId),
    .busGrant(busGrant), .busAck(busAck), .busRdata(busRdata),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpAddr(snpAddr),
    .snpId(snpId)
  );

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (memModel.exists(a)) return memModel[a];
    return 32'hC0DE0000 ^ a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpuAccess(input logic w, input logic [31:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output logic sawBus,
                           output logic earlyDone, output logic fieldsOk);
    int waitN = 0;
    bit done = 0;
    @(negedge clk);
    cpuValid = 1; cpuWrite = w; cpuAddr = a; cpuWdata = d;
    sawBus = 0; earlyDone = 0; fieldsOk = 1; rd = '0;
    for (int k = 0; k < 40 && !done; k++) begin
      #1;
      if (busReq && !busGrant) begin
        sawBus = 1;
        waitN++;
        if (busWrite !== w || busAddr !== a || busId !== 2'(MY_ID)
            || (w && busWdata !== d)) fieldsOk = 0;
        if (waitN >= 2) begin
          busGrant = 1; busAck = 1; busRdata = memRead(a);
          if (w) memModel[a] = d;
          #1;
        end
      end
      if (cpuReady) begin
        if (w && !busAck) earlyDone = 1;
        rd = cpuRdata;
        done = 1;
      end else begin
        @(negedge clk);
      end
    end
    if (!done) earlyDone = 1;
    @(negedge clk);
    cpuValid = 0; cpuWrite = 0; busGrant = 0; busAck = 0;
  endtask

  task automatic snoop(input logic w, input logic [31:0] a, input logic [1:0] id);
    @(negedge clk);
    snpValid = 1; snpWrite = w; snpAddr = a; snpId = id;
    if (w && id != 2'(MY_ID)) memModel[a] = 32'h99999999;
    @(negedge clk);
    snpValid = 0; snpWrite = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic sawBus, early, fok;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset cpuReady", 32'(cpuReady), 32'd0);
    check("R1 reset busReq", 32'(busReq), 32'd0);
    rstN = 1;

    for (int v = 0; v < NVEC; v++) begin
      cpuAccess(VEC[v][97], VEC[v][96:65], VEC[v][64:33], rd, sawBus, early, fok);
      check($sformatf("R3/R4 vec%0d bus used", v), 32'(sawBus), 32'(VEC[v][32]));
      check($sformatf("R4 vec%0d write done early", v), 32'(early), 32'd0);
      if (sawBus) check($sformatf("R3/R4 vec%0d bus fields", v), 32'(fok), 32'd1);
      if (!VEC[v][97]) check($sformatf("R2/R3 vec%0d read data", v), rd, VEC[v][31:0]);
    end

    // R7 foreign write invalidates the held line
    snoop(1'b1, 32'h10, 2'd2);
    cpuAccess(1'b0, 32'h10, 32'h0, rd, sawBus, early, fok);
    check("R7 miss after snoop", 32'(sawBus), 32'd1);
    check("R7 fresh data", rd, 32'h99999999);

    // R8 own-id snoop ignored
    snoop(1'b1, 32'h23, 2'(MY_ID));
    cpuAccess(1'b0, 32'h23, 32'h0, rd, sawBus, early, fok);
    check("R8 own snoop keeps line", 32'(sawBus), 32'd0);
    check("R8 own snoop data", rd, 32'h22222222);

    // R8 snooped read ignored
    snoop(1'b0, 32'h23, 2'd3);
    cpuAccess(1'b0, 32'h23, 32'h0, rd, sawBus, early, fok);
    check("R8 snooped read keeps line", 32'(sawBus), 32'd0);

    // R9 same index, other tag
    snoop(1'b1, 32'h13, 2'd0);
    cpuAccess(1'b0, 32'h23, 32'h0, rd, sawBus, early, fok);
    check("R9 tag mismatch keeps line", 32'(sawBus), 32'd0);
    check("R9 data", rd, 32'h22222222);

    // R1 reset clears the array
    @(negedge clk); rstN = 0;
    @(negedge clk);
    check("R1 mid reset busReq", 32'(busReq), 32'd0);
    rstN = 1;
    cpuAccess(1'b0, 32'h23, 32'h0, rd, sawBus, early, fok);
    check("R1 miss after reset", 32'(sawBus), 32'd1);
    check("R1 data after reset", rd, 32'h22222222);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule